// File: doc/BRIEF.md
# Prioritised Interrupt Controller Core

This block gathers level-sensitive interrupt requests from up to `NUM_SRC - 1` peripheral sources (ID 0 means "no interrupt") and presents one external interrupt line to a single hart. Each source has a programmable priority, an enable bit and a pending bit. A global threshold masks every source whose priority does not exceed it. Among the pending, enabled sources above threshold, the one with the highest priority wins. When two of them share that priority, the lower ID wins.

The hart reads a claim register to learn the winning ID. That read retires the pending bit and blocks the source until the hart writes the same ID back to the same register to signal completion. The register bus is a single-cycle request interface with a 12-bit byte address. Reads return their data in the same cycle. The priority, enable, pending and control registers each occupy a 1 KiB region selected by address bits [11:10]. `NUM_SRC` may range from 2 to 256.

Top module: `intc_core`

## Requirements
- R1: After reset, all priority, enable, threshold, pending and in-flight state is zero, `ext_irq_o` is low and a claim read returns 0.
- R2: The priority of source ID n lives at byte address 4·n and keeps the low 3 bits of the written data. Address 0 and IDs at or above `NUM_SRC` read as 0, and writes to them change nothing.
- R3: Enable bits are packed 32 per word from address 0x800, with source n at bit n%32 of word n/32. The bit for ID 0 and bits of unimplemented sources read as 0.
- R4: A high request on source n (n ≥ 1) sets its pending bit at the next clock edge, unless the source is in flight. Pending bits read from 0x400 in the same packing as enables. Source 0 never becomes pending.
- R5: `ext_irq_o` is high, without a register delay, exactly when some source is pending, enabled and has a priority strictly above the threshold at 0xC00.
- R6: A read of 0xC04 returns the ID of the eligible source with the highest priority, the lowest ID winning ties, or 0 when none is eligible.
- R7: A claim read that returns a nonzero ID clears that source's pending bit and marks it in flight. An in-flight source does not become pending again, even with its request held high.
- R8: Writing an in-flight ID to 0xC04 ends its flight, so a request still held high re-pends it at the following edge.
- R9: A write to 0xC04 of 0, of a value at or above `NUM_SRC`, or of an ID not in flight changes no in-flight state.
- R10: `ext_irq_o` falls in the cycle after a claim when no other source is eligible.
- R11: A source with priority 0 never raises `ext_irq_o` and is never returned by a claim, whatever the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Level request per source ID (bit 0 unused) |
| bus_req_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| ext_irq_o | output | 1 | External interrupt to the hart |

## Verification
The hardest state to reach is a source that is in flight while its request line stays high. Pending state then cannot be separated from in-flight state at the ports until a legal completion arrives. The bench claims a source, holds its request high and sends bogus completions (ID 0, an unclaimed ID, and an out-of-range value whose low bits alias the claimed ID). It then reads the pending word to show the source stayed blocked. In the sweep, every source is claimed with its request still high, then completed, and the pending word is read to show the re-arm.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BUS_AW = 12;
  localparam int unsigned BUS_DW = 32;

  typedef enum logic [1:0] {
    RGN_PRIO = 2'd0,
    RGN_PEND = 2'd1,
    RGN_EN   = 2'd2,
    RGN_CTRL = 2'd3
  } rgn_e;

  localparam logic [7:0] CTRL_THR   = 8'd0;
  localparam logic [7:0] CTRL_CLAIM = 8'd1;

  typedef struct packed {
    logic              rd;
    logic              wr;
    rgn_e              rgn;
    logic [7:0]        word;
    logic [BUS_DW-1:0] wdata;
  } bus_op_t;

  function automatic bus_op_t bus_decode(logic req, logic we,
                                         logic [BUS_AW-1:0] addr,
                                         logic [BUS_DW-1:0] wdata);
    bus_op_t op;
    op.rd    = req & ~we;
    op.wr    = req & we;
    op.rgn   = rgn_e'(addr[11:10]);
    op.word  = addr[9:2];
    op.wdata = wdata;
    return op;
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  bus_op_t                        op_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [NUM_SRC-1:0]             en_o,
  output logic [PRIO_W-1:0]              thr_o
);
  assign prio_o[0] = '0;
  assign en_o[0]   = 1'b0;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
    localparam logic [7:0] PRIO_WORD = 8'(i);
    localparam logic [7:0] EN_WORD   = 8'(i / 32);
    localparam int unsigned EN_BIT   = i % 32;
    logic [PRIO_W-1:0] prio_q;
    logic              en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q <= '0;
        en_q   <= 1'b0;
      end else if (op_i.wr) begin
        if (op_i.rgn == RGN_PRIO && op_i.word == PRIO_WORD) prio_q <= op_i.wdata[PRIO_W-1:0];
        if (op_i.rgn == RGN_EN && op_i.word == EN_WORD)     en_q   <= op_i.wdata[EN_BIT];
      end
    end

    assign prio_o[i] = prio_q;
    assign en_o[i]   = en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_o <= '0;
    else if (op_i.wr && op_i.rgn == RGN_CTRL && op_i.word == CTRL_THR)
      thr_o <= op_i.wdata[PRIO_W-1:0];
  end
endmodule

// File: rtl/intc_gateway.sv
module intc_gateway #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ID_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               claim_i,
  input  logic [ID_W-1:0]    claim_id_i,
  input  logic               done_i,
  input  logic [ID_W-1:0]    done_id_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] infl_o
);
  logic unused_src0;
  assign unused_src0 = src_i[0];
  assign pend_o[0]   = 1'b0;
  assign infl_o[0]   = 1'b0;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_gw
    localparam logic [ID_W-1:0] MY_ID = ID_W'(i);
    logic pend_q, infl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        infl_q <= 1'b0;
      end else if (claim_i && claim_id_i == MY_ID) begin
        pend_q <= 1'b0;
        infl_q <= 1'b1;
      end else begin
        // in-flight source is blocked until its completion is seen
        if (src_i[i] && !infl_q) pend_q <= 1'b1;
        if (done_i && done_id_i == MY_ID) infl_q <= 1'b0;
      end
    end

    assign pend_o[i] = pend_q;
    assign infl_o[i] = infl_q;
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 5
) (
  input  logic [NUM_SRC-1:0]             req_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic                           valid_o,
  output logic [ID_W-1:0]                id_o
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare keeps the lowest ID on a tie
  always_comb begin
    best_p  = '0;
    id_o    = '0;
    valid_o = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (req_i[i] && prio_i[i] > thr_i && prio_i[i] > best_p) begin
        best_p  = prio_i[i];
        id_o    = ID_W'(i);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [BUS_AW-1:0]  bus_addr_i,
  input  logic [BUS_DW-1:0]  bus_wdata_i,
  output logic [BUS_DW-1:0]  bus_rdata_o,
  output logic               ext_irq_o
);
  localparam int unsigned ID_W     = (NUM_SRC > 2) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned EN_WORDS = (NUM_SRC + 31) / 32;

  bus_op_t op;
  logic [1:0] unused_addr_lsb;
  assign op              = bus_decode(bus_req_i, bus_we_i, bus_addr_i, bus_wdata_i);
  assign unused_addr_lsb = bus_addr_i[1:0];

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0]             en_q;
  logic [PRIO_W-1:0]              thr;
  logic [NUM_SRC-1:0]             pend_q;
  logic [NUM_SRC-1:0]             infl_q;
  logic                           win_valid;
  logic [ID_W-1:0]                win_id;

  logic claim_rd, cmp_wr, cmp_ok;
  assign claim_rd = op.rd && op.rgn == RGN_CTRL && op.word == CTRL_CLAIM;
  assign cmp_wr   = op.wr && op.rgn == RGN_CTRL && op.word == CTRL_CLAIM;
  assign cmp_ok   = cmp_wr && op.wdata != '0 && op.wdata < BUS_DW'(NUM_SRC);

  intc_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .prio_o (prio),
    .en_o   (en_q),
    .thr_o  (thr)
  );

  intc_gateway #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_gw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (irq_src_i),
    .claim_i    (claim_rd && win_valid),
    .claim_id_i (win_id),
    .done_i     (cmp_ok),
    .done_id_i  (op.wdata[ID_W-1:0]),
    .pend_o     (pend_q),
    .infl_o     (infl_q)
  );

  intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .req_i   (pend_q & en_q),
    .prio_i  (prio),
    .thr_i   (thr),
    .valid_o (win_valid),
    .id_o    (win_id)
  );

  assign ext_irq_o = win_valid;

  logic [EN_WORDS*32-1:0] pend_pad, en_pad;
  always_comb begin
    pend_pad                = '0;
    en_pad                  = '0;
    pend_pad[NUM_SRC-1:0]   = pend_q;
    en_pad[NUM_SRC-1:0]     = en_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (op.rgn)
      RGN_PRIO: begin
        for (int i = 1; i < NUM_SRC; i++)
          if (op.word == 8'(i)) bus_rdata_o[PRIO_W-1:0] = prio[i];
      end
      RGN_PEND: begin
        for (int w = 0; w < EN_WORDS; w++)
          if (op.word == 8'(w)) bus_rdata_o = pend_pad[w*32 +: 32];
      end
      RGN_EN: begin
        for (int w = 0; w < EN_WORDS; w++)
          if (op.word == 8'(w)) bus_rdata_o = en_pad[w*32 +: 32];
      end
      RGN_CTRL: begin
        if (op.word == CTRL_THR)        bus_rdata_o[PRIO_W-1:0] = thr;
        else if (op.word == CTRL_CLAIM) bus_rdata_o[ID_W-1:0]   = win_id;
      end
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ID_W    = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_req_i,
  input logic               bus_we_i,
  input logic [11:0]        bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic [31:0]        bus_rdata_o,
  input logic               ext_irq_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] infl_q
);
  logic ctrl_claim, c_rd, c_wr, c_hit;
  assign ctrl_claim = bus_req_i && bus_addr_i[11:10] == 2'b11 && bus_addr_i[9:2] == 8'd1;
  assign c_rd       = ctrl_claim && !bus_we_i;
  assign c_wr       = ctrl_claim && bus_we_i;
  assign c_hit      = bus_wdata_i != 0 && bus_wdata_i < 32'(NUM_SRC)
                      && infl_q[bus_wdata_i[ID_W-1:0]];

  // R4
  src0_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q[0] && !infl_q[0]);

  // R5
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_o |-> (pend_q != '0));

  // R6
  claim_vs_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rd |-> ((bus_rdata_o != 0) == ext_irq_o));

  // R7
  claim_retires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rd && bus_rdata_o != 0 |=>
      infl_q[$past(bus_rdata_o[ID_W-1:0])] && !pend_q[$past(bus_rdata_o[ID_W-1:0])]);

  // R9
  bad_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr && !c_hit |=> $stable(infl_q));

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_hold
    // R7
    inflight_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      infl_q[i] |=> !pend_q[i]);
  end
endmodule

bind intc_core intc_core_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .ext_irq_o   (ext_irq_o),
  .pend_q      (pend_q),
  .infl_q      (infl_q)
);

// File: tb/test_intc_core.sv
module test_intc_core;
  localparam int NS = 16;
  localparam logic [11:0] A_PEND = 12'h400, A_EN = 12'h800, A_THR = 12'hC00, A_CLM = 12'hC04;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [NS-1:0] irq = '0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic ext_irq;

  intc_core #(.NUM_SRC(NS), .PRIO_W(3)) i_intc_core (
    .clk_i(clk), .rst_ni(rst_ni), .irq_src_i(irq), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_irq_o(ext_irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NS-1:0] pm, im, en_m;
  int prm[NS];
  int thm;
  logic [31:0] lf = 32'h1234_5678;

  task automatic check(bit ok, string r, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic do_reset();
    irq = '0; rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  function automatic logic [31:0] rnd();
    lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
    return lf;
  endfunction

  // highest priority first, then lowest ID among those
  function automatic int expect_win();
    int top = 0, id = 0;
    for (int i = 1; i < NS; i++)
      if (pm[i] && en_m[i] && prm[i] > thm && prm[i] > top) top = prm[i];
    if (top == 0) return 0;
    for (int i = NS - 1; i >= 1; i--)
      if (pm[i] && en_m[i] && prm[i] == top) id = i;
    return id;
  endfunction

  task automatic drain();
    logic [31:0] v;
    for (int k = 0; k < NS; k++) begin
      rd(A_CLM, v);
      if (v == 0) break;
      wr(A_CLM, v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1
    check(ext_irq == 0, "R1 irq", ext_irq, 0);
    rd(A_CLM, v);  check(v == 0, "R1 claim", v, 0);
    rd(12'h004, v); check(v == 0, "R1 prio", v, 0);
    rd(A_EN, v);   check(v == 0, "R1 enable", v, 0);
    rd(A_THR, v);  check(v == 0, "R1 threshold", v, 0);
    rd(A_PEND, v); check(v == 0, "R1 pending", v, 0);

    // R2
    wr(12'h014, 32'hFF);  rd(12'h014, v); check(v == 7, "R2 prio mask", v, 7);
    wr(12'h000, 32'h5);   rd(12'h000, v); check(v == 0, "R2 slot0", v, 0);
    wr(12'h050, 32'h6);   rd(12'h050, v); check(v == 0, "R2 id20", v, 0);
    rd(12'h010, v); check(v == 0, "R2 no alias id4", v, 0);

    // R3
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, v); check(v == 32'h0000_FFFE, "R3 enable word0", v, 32'hFFFE);
    wr(A_EN + 4, 32'hFFFF_FFFF); rd(A_EN + 4, v); check(v == 0, "R3 enable word1", v, 0);

    // R11: source 2 priority 0 with threshold 0
    wr(12'h008, 0); irq[2] = 1; irq[0] = 1; @(negedge clk);
    check(ext_irq == 0, "R11 irq", ext_irq, 0);
    rd(A_CLM, v); check(v == 0, "R11 claim", v, 0);
    rd(A_PEND, v); check(v == 32'h4, "R4 pending src2 only", v, 4);

    // R9 / R10: claim source 3, keep it high, bogus completions
    wr(12'h00C, 4); irq[3] = 1; @(negedge clk);
    check(ext_irq == 1, "R5 irq src3", ext_irq, 1);
    rd(A_CLM, v); check(v == 3, "R6 claim src3", v, 3);
    check(ext_irq == 0, "R10 irq drop", ext_irq, 0);
    wr(A_CLM, 5); wr(A_CLM, 0); wr(A_CLM, 32'h13);
    rd(A_PEND, v); check(v == 32'h4, "R9 still blocked", v, 4);
    wr(A_CLM, 3); @(negedge clk);
    rd(A_PEND, v); check(v == 32'hC, "R8 re-pend src3", v, 32'hC);

    // sweep
    for (int t = 0; t < 120; t++) begin
      do_reset();
      for (int i = 1; i < NS; i++) begin
        prm[i] = int'(rnd() % 8);
        wr(12'(4 * i), 32'(prm[i]));
      end
      v = rnd(); en_m = v[NS-1:0]; en_m[0] = 0;
      wr(A_EN, 32'(v[NS-1:0]));
      thm = int'(rnd() % 5);
      wr(A_THR, 32'(thm));
      v = rnd(); irq = v[NS-1:0];
      @(negedge clk);
      pm = irq; pm[0] = 0; im = '0;
      rd(A_PEND, v); check(v == 32'(pm), "R4 sweep pending", v, pm);
      for (int k = 0; k < NS; k++) begin
        int e;
        e = expect_win();
        check(ext_irq == (e != 0), "R5 R10 sweep irq", ext_irq, e != 0);
        rd(A_CLM, v); check(v == 32'(e), "R6 sweep claim", v, e);
        if (e == 0) break;
        pm[e] = 0; im[e] = 1;
      end
      rd(A_PEND, v); check(v == 32'(pm), "R7 no re-pend in flight", v, pm);
      for (int i = 1; i < NS; i++) if (im[i]) wr(A_CLM, 32'(i));
      @(negedge clk);
      rd(A_PEND, v); check(v == 32'(pm | im), "R8 sweep re-arm", v, pm | im);
      irq = '0;
      wr(A_THR, 0); wr(A_EN, 32'hFFFF);
      for (int i = 1; i < NS; i++) wr(12'(4 * i), 1);
      drain();
      rd(A_PEND, v); check(v == 0, "R7 drained", v, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule